// File: doc/BRIEF.md
# Protected Boot Mode Controller

This block holds the processor's protection mode and decides, for each instruction request, whether the request is allowed in that mode. Reset always starts the processor in a restricted test mode. In that mode only one program runs, firmware services are switched off, and store accesses are confined to the lowest 64 KiB. A dedicated switch instruction moves the processor into full protected mode. Software has no way to leave full mode again.

Each request arrives with a valid strobe, a two-bit instruction class and an access address. The controller registers an illegal-instruction fault and an address fault, and both appear one cycle after the strobe. A request that faults never changes the mode. An operator-panel return request is the only path from full mode back to test mode. Taking that path also emits a one-cycle pulse, which tells the rest of the system that the running software has been lost. Executing the instruction is the job of other logic.

Top module: `boot_mode_ctrl`

## Requirements
- R1: While reset is asserted, and after it is released, the block is in test mode (`mode_full_o` = 0) with `illegal_fault_o`, `addr_fault_o` and `sw_abort_o` all low.
- R2: In test mode, a valid request whose address is 0x10000 or higher sets `addr_fault_o` in the next cycle. An address of 0xFFFF or lower raises no address fault. In full mode no address raises an address fault.
- R3: Instruction classes are encoded as 0 ordinary, 1 firmware service, 2 flat 32-bit addressing and 3 switch-to-full. In test mode, classes 1 and 2 set `illegal_fault_o` in the next cycle. Classes 0 and 3 do not.
- R4: A valid class-3 request in test mode with an address below 0x10000 sets `mode_full_o` in the next cycle.
- R5: Once in full mode, the block stays there for every instruction class and address until the panel return input is sampled high, or until reset.
- R6: In full mode, classes 0, 1 and 2 raise no fault. Class 3 sets `illegal_fault_o` in the next cycle.
- R7: When the panel return input is sampled high in full mode, the next cycle shows `sw_abort_o` high for exactly one cycle and `mode_full_o` low. In test mode the panel input causes no pulse and leaves the mode in test.
- R8: Fault outputs are low in any cycle that does not follow a valid strobe. A faulted request leaves the mode unchanged.
- R9: When the panel return input and a class-3 request arrive in the same cycle, the panel input wins and the block ends up in test mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| panel_return_i | input | 1 | Operator panel request to return to test mode |
| instr_valid_i | input | 1 | Request strobe for class and address |
| instr_class_i | input | 2 | Instruction class (0 ordinary, 1 service, 2 flat, 3 switch) |
| access_addr_i | input | ADDR_W (24) | Byte address the request touches |
| mode_full_o | output | 1 | 1 in full protected mode, 0 in test mode |
| illegal_fault_o | output | 1 | Registered illegal-instruction fault |
| addr_fault_o | output | 1 | Registered out-of-window address fault |
| sw_abort_o | output | 1 | One-cycle pulse: running software lost on panel return |

## Verification
Several rules are checked by the assertions on every clock cycle:
- the per-request legality rules: window faults and class faults in test mode, and the switch fault in full mode;
- the one-way nature of full mode when the panel is idle;
- the abort pulse that follows a panel return from full mode;
- the silence of the fault outputs without a strobe.

Some behaviour can only be shown by the bench scenarios. These include the reset state, the exact 0xFFFF/0x10000 window edge, the fact that a switch carrying a bad address stays in test mode, the panel and switch collision, and a full round trip from test mode to full mode and back through the panel.

// File: rtl/boot_mode_pkg.sv
// Package: shared encodings for the protection-mode controller.
// Assumes two-bit instruction class codes fixed by the decode stage upstream.
package boot_mode_pkg;

    // Instruction classes as presented by the instruction decoder
    typedef enum logic [1:0] {
        CLS_ORDINARY = 2'd0,
        CLS_SERVICE  = 2'd1,
        CLS_FLAT     = 2'd2,
        CLS_SWITCH   = 2'd3
    } instr_cls_e;

    // Protection mode held by the controller
    typedef enum logic {
        PMODE_TEST = 1'b0,
        PMODE_FULL = 1'b1
    } pmode_e;

endpackage

// File: rtl/boot_mode_decode.sv
// Module: boot_mode_decode
// Purely combinational legality check of one request against the current mode.
// Assumes the address is a byte address and that the test-mode window begins
// at zero and spans 2**WIN_BITS bytes.
module boot_mode_decode
    import boot_mode_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int WIN_BITS = 16
) (
    input  pmode_e           mode_i,
    input  logic             valid_i,
    input  instr_cls_e       cls_i,
    input  logic [ADDR_W-1:0] addr_i,
    output logic             illegal_o,
    output logic             addr_bad_o,
    output logic             switch_ok_o
);

    logic beyond_window;

    // Window compare: only exists when the address can reach past the window
    generate
        if (ADDR_W > WIN_BITS) begin : g_wide
            assign beyond_window = |addr_i[ADDR_W-1:WIN_BITS];
        end else begin : g_narrow
            assign beyond_window = 1'b0;
        end
    endgenerate

    // Class legality per mode, address window in test mode only
    always_comb begin
        illegal_o  = 1'b0;
        addr_bad_o = 1'b0;
        if (valid_i) begin
            if (mode_i == PMODE_TEST) begin
                illegal_o  = (cls_i == CLS_SERVICE) || (cls_i == CLS_FLAT);
                addr_bad_o = beyond_window;
            end else begin
                illegal_o  = (cls_i == CLS_SWITCH);
            end
        end
    end

    // Switch is honoured only when it raises no fault of either kind
    assign switch_ok_o = valid_i && (mode_i == PMODE_TEST) &&
                         (cls_i == CLS_SWITCH) && !addr_bad_o;

endmodule

// File: rtl/boot_mode_state.sv
// Module: boot_mode_state
// Holds the protection mode register and produces the software-abort pulse.
// Assumes the panel request outranks any same-cycle switch instruction.
module boot_mode_state
    import boot_mode_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   panel_return_i,
    input  logic   switch_ok_i,
    output pmode_e mode_o,
    output logic   sw_abort_o
);

    pmode_e mode_q;
    logic   abort_q;

    // Mode transitions: panel return first, then the software switch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= PMODE_TEST;
            abort_q <= 1'b0;
        end else begin
            abort_q <= panel_return_i && (mode_q == PMODE_FULL);
            if (panel_return_i) begin
                mode_q <= PMODE_TEST;
            end else if (switch_ok_i) begin
                mode_q <= PMODE_FULL;
            end
        end
    end

    assign mode_o     = mode_q;
    assign sw_abort_o = abort_q;

endmodule

// File: rtl/boot_mode_fault.sv
// Module: boot_mode_fault
// Registers the two fault flags so they appear one cycle after the strobe.
// Assumes the inputs are already qualified by the request strobe.
module boot_mode_fault (
    input  logic clk,
    input  logic rst_n,
    input  logic illegal_i,
    input  logic addr_bad_i,
    output logic illegal_o,
    output logic addr_bad_o
);

    // Capture this cycle's verdict for presentation next cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            illegal_o  <= 1'b0;
            addr_bad_o <= 1'b0;
        end else begin
            illegal_o  <= illegal_i;
            addr_bad_o <= addr_bad_i;
        end
    end

endmodule

// File: rtl/boot_mode_ctrl.sv
// Module: boot_mode_ctrl (top)
// Protection-mode controller: starts in test mode, allows a one-way switch to
// full mode, flags illegal instructions and out-of-window accesses, and returns
// to test mode only on an operator panel request.
// Assumes one request per cycle and that instruction execution happens elsewhere.
module boot_mode_ctrl
    import boot_mode_pkg::*;
#(
    parameter int ADDR_W   = 24,
    parameter int WIN_BITS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              panel_return_i,
    input  logic              instr_valid_i,
    input  logic [1:0]        instr_class_i,
    input  logic [ADDR_W-1:0] access_addr_i,
    output logic              mode_full_o,
    output logic              illegal_fault_o,
    output logic              addr_fault_o,
    output logic              sw_abort_o
);

    pmode_e     cur_mode;
    instr_cls_e req_cls;
    logic       illegal_now;
    logic       addr_bad_now;
    logic       switch_ok;

    assign req_cls = instr_cls_e'(instr_class_i);

    boot_mode_decode #(
        .ADDR_W   (ADDR_W),
        .WIN_BITS (WIN_BITS)
    ) u_decode (
        .mode_i      (cur_mode),
        .valid_i     (instr_valid_i),
        .cls_i       (req_cls),
        .addr_i      (access_addr_i),
        .illegal_o   (illegal_now),
        .addr_bad_o  (addr_bad_now),
        .switch_ok_o (switch_ok)
    );

    boot_mode_state u_state (
        .clk            (clk),
        .rst_n          (rst_n),
        .panel_return_i (panel_return_i),
        .switch_ok_i    (switch_ok),
        .mode_o         (cur_mode),
        .sw_abort_o     (sw_abort_o)
    );

    boot_mode_fault u_fault (
        .clk        (clk),
        .rst_n      (rst_n),
        .illegal_i  (illegal_now),
        .addr_bad_i (addr_bad_now),
        .illegal_o  (illegal_fault_o),
        .addr_bad_o (addr_fault_o)
    );

    assign mode_full_o = (cur_mode == PMODE_FULL);

endmodule

// File: rtl/boot_mode_ctrl_chk.sv
// Module: boot_mode_ctrl_chk
// Port-level temporal checks for boot_mode_ctrl, attached by bind below.
// Assumes the same parameters as the top it observes.
module boot_mode_ctrl_chk #(
    parameter int ADDR_W   = 24,
    parameter int WIN_BITS = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              panel_return_i,
    input logic              instr_valid_i,
    input logic [1:0]        instr_class_i,
    input logic [ADDR_W-1:0] access_addr_i,
    input logic              mode_full_o,
    input logic              illegal_fault_o,
    input logic              addr_fault_o,
    input logic              sw_abort_o
);

    logic outside;
    assign outside = (access_addr_i >> WIN_BITS) != '0;

    // R2
    window_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid_i && !mode_full_o && outside |=> addr_fault_o);

    // R2
    full_no_addr_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_full_o |=> !addr_fault_o);

    // R3
    test_class_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid_i && !mode_full_o && (instr_class_i == 2'd1 || instr_class_i == 2'd2)
        |=> illegal_fault_o);

    // R4
    switch_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid_i && !mode_full_o && instr_class_i == 2'd3 && !outside && !panel_return_i
        |=> mode_full_o);

    // R5
    full_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_full_o && !panel_return_i |=> mode_full_o);

    // R6
    full_switch_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        instr_valid_i && mode_full_o && instr_class_i == 2'd3 |=> illegal_fault_o);

    // R7
    abort_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode_full_o && panel_return_i |=> sw_abort_o && !mode_full_o);

    // R7
    abort_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sw_abort_o |=> !sw_abort_o);

    // R8
    quiet_fault_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid_i |=> !illegal_fault_o && !addr_fault_o);

endmodule

bind boot_mode_ctrl boot_mode_ctrl_chk #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (WIN_BITS)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .panel_return_i  (panel_return_i),
    .instr_valid_i   (instr_valid_i),
    .instr_class_i   (instr_class_i),
    .access_addr_i   (access_addr_i),
    .mode_full_o     (mode_full_o),
    .illegal_fault_o (illegal_fault_o),
    .addr_fault_o    (addr_fault_o),
    .sw_abort_o      (sw_abort_o)
);

// File: tb/boot_mode_ctrl_test.sv
// Scoreboard bench for boot_mode_ctrl: the driver predicts each request's
// outcome from the requirements; the monitor compares after the next edge.
module boot_mode_ctrl_test;

    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          panel;
    logic          valid;
    logic [1:0]    cls;
    logic [AW-1:0] addr;
    logic          mode_full, ill, adf, abt;

    int  vectors = 0;
    int  errors  = 0;
    bit  done    = 0;
    logic model_full;

    logic [3:0] expq[$];
    string      tagq[$];

    always #4 clk = ~clk;

    boot_mode_ctrl #(.ADDR_W(AW), .WIN_BITS(16)) uut (
        .clk             (clk),
        .rst_n           (rst_n),
        .panel_return_i  (panel),
        .instr_valid_i   (valid),
        .instr_class_i   (cls),
        .access_addr_i   (addr),
        .mode_full_o     (mode_full),
        .illegal_fault_o (ill),
        .addr_fault_o    (adf),
        .sw_abort_o      (abt)
    );

    // Compare one observation against its prediction
    task automatic check(input string tag, input logic [3:0] act, input logic [3:0] exp);
        vectors++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s {mode,ill,adf,abort} actual=%b expected=%b", tag, act, exp);
        end
    endtask

    // Driver: apply one request at the falling edge and predict its result
    task automatic issue(input logic v, input logic [1:0] c, input logic [AW-1:0] a,
                         input logic p, input string tag);
        logic e_ill, e_adf, e_abt, nxt;
        @(negedge clk);
        valid = v; cls = c; addr = a; panel = p;
        e_ill = v && (model_full ? (c == 2'd3) : (c == 2'd1 || c == 2'd2));
        e_adf = v && !model_full && (a >= 24'h010000);
        e_abt = p && model_full;
        nxt   = model_full;
        if (p) nxt = 1'b0;
        else if (v && !model_full && c == 2'd3 && !e_adf) nxt = 1'b1;
        model_full = nxt;
        expq.push_back({nxt, e_ill, e_adf, e_abt});
        tagq.push_back(tag);
    endtask

    // Monitor: sample after each rising edge and pop the matching prediction
    always @(posedge clk) begin
        logic [3:0] e;
        string t;
        #2;
        if (expq.size() > 0) begin
            e = expq.pop_front();
            t = tagq.pop_front();
            check(t, {mode_full, ill, adf, abt}, e);
        end
    end

    // Stimulus sequence
    initial begin
        rst_n = 1'b0; panel = 1'b0; valid = 1'b0; cls = 2'd0; addr = '0;
        model_full = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset", {mode_full, ill, adf, abt}, 4'b0000);
        rst_n = 1'b1;

        issue(1, 2'd0, 24'h000100, 0, "R3 ordinary in test");
        issue(1, 2'd0, 24'h00FFFF, 0, "R2 window top edge");
        issue(1, 2'd0, 24'h010000, 0, "R2 window first outside");
        issue(1, 2'd0, 24'hFFFFFF, 0, "R2 far outside");
        issue(1, 2'd1, 24'h000010, 0, "R3 service in test");
        issue(1, 2'd2, 24'h000010, 0, "R3 flat in test");
        issue(0, 2'd1, 24'h800000, 0, "R8 no strobe no fault");
        issue(1, 2'd3, 24'h020000, 0, "R8 faulted switch keeps test");
        issue(1, 2'd3, 24'h000200, 1, "R9 panel beats switch");
        issue(0, 2'd0, 24'h000000, 1, "R7 panel in test no pulse");
        issue(1, 2'd3, 24'h000200, 0, "R4 switch to full");
        issue(1, 2'd0, 24'h400000, 0, "R2 no window in full");
        issue(1, 2'd1, 24'h000000, 0, "R6 service legal in full");
        issue(1, 2'd2, 24'h123456, 0, "R6 flat legal in full");
        issue(1, 2'd3, 24'h000000, 0, "R6 switch illegal in full");
        issue(0, 2'd0, 24'h000000, 0, "R5 full holds idle");
        issue(1, 2'd3, 24'h000040, 1, "R7 panel return abort");
        issue(0, 2'd0, 24'h000000, 0, "R7 abort single cycle");
        issue(1, 2'd3, 24'h000000, 0, "R4 re-enter full");
        issue(0, 2'd0, 24'h000000, 0, "R5 settle");
        @(negedge clk);
        rst_n = 1'b0; valid = 1'b0; panel = 1'b0;
        @(negedge clk);
        check("R1 reset from full", {mode_full, ill, adf, abt}, 4'b0000);
        model_full = 1'b0;
        rst_n = 1'b1;
        issue(1, 2'd1, 24'h000000, 0, "R1 test mode after reset");
        issue(0, 2'd0, 24'h000000, 0, "R8 drain");
        repeat (2) @(negedge clk);
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check
    initial begin
        #(200000 * 8);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

endmodule